// File: doc/BRIEF.md
# Programmable AND-OR Logic Array

This block is a small field-configurable sum-of-products engine. Both of its planes are set by configuration bits. The AND plane builds each product term from any mix of true and complemented input literals. The OR plane lets every output collect any subset of those terms. A single term may therefore serve several outputs at once. A per-output inversion bit sits behind the OR plane, so the complement of a function can be built when it needs fewer terms.

Configuration is loaded as flat vectors in one write cycle and held in registers. The input vector is evaluated through both planes every cycle, and the result is registered onto the output. The input, term and output counts are parameters. The defaults of three inputs, eight terms and two outputs are enough for a one-bit full adder: the sum uses four terms, the carry uses three, and one term is spare.

Top module: `pla_array`

## Requirements
- R1: A synchronous active-high reset clears every configuration register and drives `out_vec` to zero. After reset, with nothing loaded, every output stays 0 for any input.
- R2: Every input supplies a true literal and a complement literal. Bit `t*2*N_IN + 2*i` of `and_cfg` connects the true form of input i to term t. Bit `t*2*N_IN + 2*i + 1` connects the complement form.
- R3: A configuration bit of 0 removes its literal, which then reads as high. A term with no literal connected is therefore constantly high, and any non-inverted output connected to it reads 1.
- R4: Bit `o*N_TERM + t` of `or_cfg` set to 1 makes output o include term t. The output is the OR of all the terms it includes.
- R5: One product term can feed several outputs at the same time.
- R6: An output whose `or_cfg` bits are all 0 evaluates low when its inversion bit is 0.
- R7: Bit o of `inv_cfg` set to 1 inverts output o after the OR plane.
- R8: `out_vec` shows the function of the inputs sampled at the previous rising edge. The configuration used is the one held before that edge. A write with `cfg_we` high is used from the next evaluation onward.
- R9: The full-adder configuration gives a correct sum and carry for all 8 input combinations. The sum uses four terms and the carry uses three.
- R10: While the inputs and the configuration are held, `out_vec` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Loads all three configuration vectors on this edge |
| and_cfg | input | 2*N_IN*N_TERM | AND-plane connection bits, 1 = literal included |
| or_cfg | input | N_TERM*N_OUT | OR-plane connection bits, 1 = term included |
| inv_cfg | input | N_OUT | Per-output inversion bits |
| in_vec | input | N_IN | Logic inputs |
| out_vec | output | N_OUT | Registered logic outputs |

## Verification
The bench builds the block with its default sizes of three inputs, eight terms and two outputs. This covers the whole input space in eight patterns. It also leaves room for the full adder's seven terms plus one spare term, which is used as an always-high term. Each pattern set is loaded as a separate configuration: the adder, the inverted adder, complement literals, a term shared by both outputs, and an empty term. A configuration write is made in the same cycle as an input change, to show which configuration produced each result.

// File: rtl/pla_pkg.sv
package pla_pkg;

  // Position of a literal bit in the flat AND-plane vector
  function automatic int and_bit_pos(input int term, input int inp,
                                     input bit comp, input int n_in);
    return term * 2 * n_in + 2 * inp + (comp ? 1 : 0);
  endfunction

  // Position of a term bit in the flat OR-plane vector
  function automatic int or_bit_pos(input int outp, input int term,
                                    input int n_term);
    return outp * n_term + term;
  endfunction

endpackage

// File: rtl/pla_cfg_regs.sv
module pla_cfg_regs #(
  parameter int N_IN   = 3,
  parameter int N_TERM = 8,
  parameter int N_OUT  = 2,
  localparam int AW = 2 * N_IN * N_TERM,
  localparam int OW = N_TERM * N_OUT
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] and_d,
  input  logic [OW-1:0] or_d,
  input  logic [N_OUT-1:0] inv_d,
  output logic [AW-1:0] and_q,
  output logic [OW-1:0] or_q,
  output logic [N_OUT-1:0] inv_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      and_q <= '0;
      or_q  <= '0;
      inv_q <= '0;
    end else if (we) begin
      and_q <= and_d;
      or_q  <= or_d;
      inv_q <= inv_d;
    end
  end

endmodule

// File: rtl/pla_and_plane.sv
module pla_and_plane
  import pla_pkg::*;
#(
  parameter int N_IN   = 3,
  parameter int N_TERM = 8,
  localparam int AW = 2 * N_IN * N_TERM,
  localparam int LW = 2 * N_IN
) (
  input  logic [N_IN-1:0]   in_vec,
  input  logic [AW-1:0]     and_mask,
  output logic [N_TERM-1:0] terms
);

  // Literal rail: even slots true, odd slots complement
  logic [LW-1:0] lits;

  always_comb begin
    for (int i = 0; i < N_IN; i++) begin
      lits[2*i]     = in_vec[i];
      lits[2*i + 1] = ~in_vec[i];
    end
  end

  for (genvar t = 0; t < N_TERM; t++) begin : g_term
    logic [LW-1:0] sel;
    assign sel = and_mask[t*LW +: LW];
    // A removed connection reads as high
    assign terms[t] = &(lits | ~sel);
  end

endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane #(
  parameter int N_TERM = 8,
  parameter int N_OUT  = 2,
  localparam int OW = N_TERM * N_OUT
) (
  input  logic [N_TERM-1:0] terms,
  input  logic [OW-1:0]     or_mask,
  input  logic [N_OUT-1:0]  inv,
  output logic [N_OUT-1:0]  funcs
);

  for (genvar o = 0; o < N_OUT; o++) begin : g_out
    logic [N_TERM-1:0] picked;
    assign picked   = terms & or_mask[o*N_TERM +: N_TERM];
    assign funcs[o] = (|picked) ^ inv[o];
  end

endmodule

// File: rtl/pla_array.sv
module pla_array #(
  parameter int N_IN   = 3,
  parameter int N_TERM = 8,
  parameter int N_OUT  = 2,
  localparam int AW = 2 * N_IN * N_TERM,
  localparam int OW = N_TERM * N_OUT
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [AW-1:0]    and_cfg,
  input  logic [OW-1:0]    or_cfg,
  input  logic [N_OUT-1:0] inv_cfg,
  input  logic [N_IN-1:0]  in_vec,
  output logic [N_OUT-1:0] out_vec
);

  logic [AW-1:0]     and_q;
  logic [OW-1:0]     or_q;
  logic [N_OUT-1:0]  inv_q;
  logic [N_TERM-1:0] terms;
  logic [N_OUT-1:0]  funcs;

  pla_cfg_regs #(.N_IN(N_IN), .N_TERM(N_TERM), .N_OUT(N_OUT)) u_cfg (
    .clk   (clk),
    .rst   (rst),
    .we    (cfg_we),
    .and_d (and_cfg),
    .or_d  (or_cfg),
    .inv_d (inv_cfg),
    .and_q (and_q),
    .or_q  (or_q),
    .inv_q (inv_q)
  );

  pla_and_plane #(.N_IN(N_IN), .N_TERM(N_TERM)) u_and (
    .in_vec   (in_vec),
    .and_mask (and_q),
    .terms    (terms)
  );

  pla_or_plane #(.N_TERM(N_TERM), .N_OUT(N_OUT)) u_or (
    .terms   (terms),
    .or_mask (or_q),
    .inv     (inv_q),
    .funcs   (funcs)
  );

  always_ff @(posedge clk) begin
    if (rst) out_vec <= '0;
    else     out_vec <= funcs;
  end

endmodule

// File: rtl/pla_array_chk.sv
module pla_array_chk #(
  parameter int N_IN   = 3,
  parameter int N_TERM = 8,
  parameter int N_OUT  = 2,
  localparam int AW = 2 * N_IN * N_TERM,
  localparam int OW = N_TERM * N_OUT,
  localparam int LW = 2 * N_IN
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_we,
  input logic [AW-1:0]    and_cfg,
  input logic [OW-1:0]    or_cfg,
  input logic [N_OUT-1:0] inv_cfg,
  input logic [N_IN-1:0]  in_vec,
  input logic [N_OUT-1:0] out_vec
);

  // Configuration as seen from the ports
  logic [AW-1:0]     and_sh;
  logic [OW-1:0]     or_sh;
  logic [N_OUT-1:0]  inv_sh;
  logic              wr_prev;
  logic [N_OUT-1:0]  mask_empty;
  logic [N_OUT-1:0]  hits_open_term;

  always_ff @(posedge clk) begin
    if (rst) begin
      and_sh  <= '0;
      or_sh   <= '0;
      inv_sh  <= '0;
      wr_prev <= 1'b0;
    end else begin
      wr_prev <= cfg_we;
      if (cfg_we) begin
        and_sh <= and_cfg;
        or_sh  <= or_cfg;
        inv_sh <= inv_cfg;
      end
    end
  end

  always_comb begin
    for (int o = 0; o < N_OUT; o++) begin
      mask_empty[o]     = (or_sh[o*N_TERM +: N_TERM] == '0);
      hits_open_term[o] = 1'b0;
      for (int t = 0; t < N_TERM; t++)
        if (or_sh[o*N_TERM + t] && and_sh[t*LW +: LW] == '0)
          hits_open_term[o] = 1'b1;
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> out_vec == '0);

  // R10
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !wr_prev && $stable(in_vec)) |=> $stable(out_vec));

  for (genvar o = 0; o < N_OUT; o++) begin : g_chk
    // R6
    empty_low_chk: assert property (@(posedge clk) disable iff (rst)
      (mask_empty[o] && !inv_sh[o]) |=> !out_vec[o]);
    // R7
    empty_inv_chk: assert property (@(posedge clk) disable iff (rst)
      (mask_empty[o] && inv_sh[o]) |=> out_vec[o]);
    // R3
    open_term_chk: assert property (@(posedge clk) disable iff (rst)
      (hits_open_term[o] && !inv_sh[o]) |=> out_vec[o]);
  end

endmodule

bind pla_array pla_array_chk #(.N_IN(N_IN), .N_TERM(N_TERM), .N_OUT(N_OUT)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .cfg_we  (cfg_we),
  .and_cfg (and_cfg),
  .or_cfg  (or_cfg),
  .inv_cfg (inv_cfg),
  .in_vec  (in_vec),
  .out_vec (out_vec)
);

// File: tb/sim_pla_array.sv
module sim_pla_array;
  localparam int N_IN   = 3;
  localparam int N_TERM = 8;
  localparam int N_OUT  = 2;
  localparam int AW = 2 * N_IN * N_TERM;
  localparam int OW = N_TERM * N_OUT;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             cfg_we = 1'b0;
  logic [AW-1:0]    and_cfg = '0;
  logic [OW-1:0]    or_cfg = '0;
  logic [N_OUT-1:0] inv_cfg = '0;
  logic [N_IN-1:0]  in_vec = '0;
  logic [N_OUT-1:0] out_vec;

  always #4 clk = ~clk;  // 125 MHz

  pla_array #(.N_IN(N_IN), .N_TERM(N_TERM), .N_OUT(N_OUT)) u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .and_cfg(and_cfg),
    .or_cfg(or_cfg), .inv_cfg(inv_cfg), .in_vec(in_vec), .out_vec(out_vec)
  );

  typedef struct {
    logic [N_OUT-1:0] exp;
    int               due;
    string            tag;
  } item_t;

  item_t sb[$];
  int cyc = 0;
  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  task automatic check(input string tag, input logic [N_OUT-1:0] act,
                       input logic [N_OUT-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // Monitor: compares each expectation in its due cycle
  always @(posedge clk) begin
    cyc++;
    #2;
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      item_t it;
      it = sb.pop_front();
      check(it.tag, out_vec, it.exp);
    end
  end

  // Driver: inputs at a falling edge, result due after next rising edge
  task automatic drive(input logic [N_IN-1:0] v, input logic [N_OUT-1:0] e,
                       input string tag);
    item_t it;
    @(negedge clk);
    in_vec = v;
    it.exp = e;
    it.due = cyc + 1;
    it.tag = tag;
    sb.push_back(it);
  endtask

  // Staged configuration built by the bench
  logic [AW-1:0]    st_and;
  logic [OW-1:0]    st_or;
  logic [N_OUT-1:0] st_inv;

  task automatic clear_stage();
    st_and = '0; st_or = '0; st_inv = '0;
  endtask

  task automatic lit(input int t, input int i, input bit comp);
    st_and[t*2*N_IN + 2*i + (comp ? 1 : 0)] = 1'b1;
  endtask

  task automatic use_term(input int o, input int t);
    st_or[o*N_TERM + t] = 1'b1;
  endtask

  task automatic load();
    @(negedge clk);
    and_cfg = st_and; or_cfg = st_or; inv_cfg = st_inv; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic build_adder();
    clear_stage();
    // sum terms 0..3: a'b'c, a'bc', ab'c', abc
    lit(0,0,1); lit(0,1,1); lit(0,2,0);
    lit(1,0,1); lit(1,1,0); lit(1,2,1);
    lit(2,0,0); lit(2,1,1); lit(2,2,1);
    lit(3,0,0); lit(3,1,0); lit(3,2,0);
    // carry terms 4..6: ab, ac, bc
    lit(4,0,0); lit(4,1,0);
    lit(5,0,0); lit(5,2,0);
    lit(6,1,0); lit(6,2,0);
    for (int t = 0; t < 4; t++) use_term(0, t);
    for (int t = 4; t < 7; t++) use_term(1, t);
  endtask

  task automatic wait_drain();
    while (sb.size() > 0) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 out during reset", out_vec, '0);
    rst = 1'b0;
    // R1 / R6: nothing loaded, outputs low
    for (int v = 0; v < 8; v += 7) drive(v[N_IN-1:0], 2'b00, "R1 unloaded");

    // R9 / R4: full adder
    build_adder();
    load();
    for (int v = 0; v < 8; v++) begin
      int s;
      s = v[0] + v[1] + v[2];
      drive(v[N_IN-1:0], {s[1], s[0]}, "R9 full adder");
    end
    // R10: held inputs
    for (int k = 0; k < 3; k++) drive(3'b110, 2'b10, "R10 hold");

    // R7: inverted adder
    build_adder();
    st_inv = 2'b11;
    load();
    for (int v = 0; v < 8; v++) begin
      int s;
      s = v[0] + v[1] + v[2];
      drive(v[N_IN-1:0], ~{s[1], s[0]}, "R7 inverted");
    end

    // R2: complement literals, out0 = ~a, out1 = b & ~c
    clear_stage();
    lit(0,0,1); lit(1,1,0); lit(1,2,1);
    use_term(0,0); use_term(1,1);
    load();
    for (int v = 0; v < 8; v++)
      drive(v[N_IN-1:0], {v[1] & ~v[2], ~v[0]}, "R2 literals");

    // R5: one term (a & b) shared by both outputs
    clear_stage();
    lit(0,0,0); lit(0,1,0);
    use_term(0,0); use_term(1,0);
    load();
    for (int v = 0; v < 8; v++)
      drive(v[N_IN-1:0], {2{v[0] & v[1]}}, "R5 sharing");

    // R8: write in the same cycle as an input change
    wait_drain();
    clear_stage();
    @(negedge clk);
    in_vec = 3'b011;
    and_cfg = st_and; or_cfg = st_or; inv_cfg = st_inv; cfg_we = 1'b1;
    begin
      item_t it;
      it.exp = 2'b11; it.due = cyc + 1; it.tag = "R8 old config used";
      sb.push_back(it);
    end
    @(negedge clk);
    cfg_we = 1'b0;
    drive(3'b011, 2'b00, "R8 new config used");

    // R3 / R6: empty term 5 on out1, out0 empty mask
    clear_stage();
    lit(0,0,0);
    use_term(1,5);
    load();
    for (int v = 0; v < 8; v += 3) drive(v[N_IN-1:0], 2'b10, "R3 open term, R6 empty");

    // R1: reset clears loaded configuration
    build_adder();
    load();
    drive(3'b011, 2'b10, "R9 before reset");
    wait_drain();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R1 reset out", out_vec, '0);
    rst = 1'b0;
    drive(3'b011, 2'b00, "R1 config cleared");
    drive(3'b111, 2'b00, "R1 config cleared");

    wait_drain();
    @(negedge clk);
    finish_run();
  end

endmodule